// File: doc/BRIEF.md
# Oversampling Sample Accumulator

This block sits between a 12-bit converter's sample stream and a 16-bit result register. A start trigger opens a group. The block then adds up a programmable, power-of-two count of strobed samples in a wide accumulator. When the last sample of the group arrives, it divides the sum by a programmable power of two and stores the value in the result register. It marks that update with a one-cycle done pulse.

In single mode, each trigger gives exactly one result. In continuous mode, a new group opens as soon as the previous result is stored, with no new trigger. Results therefore arrive at the raw sample rate divided by the group size. If enable drops during a group, or the continuous flag drops during a continuous group, the partial sum is thrown away. Samples that arrive while idle and triggers that arrive while busy have no effect.

Top module: `ovs_accum`

## Requirements
- R1: After reset, result is 0, and done and busy are low.
- R2: A trigger with enable high while idle sets busy from the next cycle. On that same edge, the block captures the group size N = 2^(ratio_code+1) (codes 0..7 give N = 2..256) and the shift amount.
- R3: The result equals the sum of exactly N strobed samples, shifted right by the captured shift. The 20-bit accumulator holds 256 × 4095 without wrapping. Example: N = 64, shift 2 and full-scale input give 65520.
- R4: When the shifted sum exceeds 65535, the result is 65535 (0xFFFF) and does not wrap.
- R5: Shift values 9..15 act as a shift of 8.
- R6: Done is high for exactly one cycle: the cycle after the edge that captures the group's last sample. The result changes in that same cycle and holds its value at all other times.
- R7: In single mode, busy drops in the same cycle that done rises.
- R8: In continuous mode, busy stays high after done and the next group accumulates without a trigger. At each group boundary, the block takes ratio_code and shift_amt afresh.
- R9: If enable is low while busy, or cont_mode is low during a continuous group, the group is discarded. Busy is low on the next cycle, no done follows, the result is unchanged, and the next group starts from a zero sum.
- R10: Sample strobes while idle change nothing.
- R11: Triggers while busy change neither the group size nor the group progress.
- R12: A trigger with enable low does not start a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low aborts a group |
| cont_mode | input | 1 | Continuous-mode flag |
| trigger | input | 1 | Start of a group |
| ratio_code | input | 3 | Group size code, N = 2^(code+1) |
| shift_amt | input | 4 | Right shift, 0..8 (larger values act as 8) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Sample value |
| result | output | 16 | Scaled group result |
| done | output | 1 | One-cycle pulse when result updates |
| busy | output | 1 | A group is open |

## Verification
The bench builds the block with its default widths: 12-bit samples, a 3-bit ratio code, a 4-bit shift field, a 20-bit accumulator and a 16-bit result. These widths make every group size from 2 to 256 reachable. They also allow a 256-sample full-scale group that fills the whole accumulator, and shift fields above the legal maximum. A behavioural queue model is compared against the outputs on every cycle. Directed groups are added on top of that comparison: full range, saturation, shift clamping, aborts in mid-group, and a continuous run whose group size changes at a group boundary.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
    localparam int SAMPLE_W  = 12;
    localparam int RES_W     = 16;
    localparam int CODE_W    = 3;
    localparam int SHIFT_W   = 4;
    localparam int MAX_SHIFT = 8;
endpackage

// File: rtl/ovs_scale.sv
module ovs_scale #(
    parameter int ACC_W     = 20,
    parameter int RES_W     = 16,
    parameter int SHIFT_W   = 4,
    parameter int MAX_SHIFT = 8
) (
    input  logic [ACC_W-1:0]   sum,
    input  logic [SHIFT_W-1:0] shift,
    output logic [RES_W-1:0]   scaled
);
    logic [SHIFT_W-1:0] eff_shift;
    logic [ACC_W-1:0]   shifted;

    always_comb begin
        eff_shift = (shift > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : shift;
        shifted   = sum >> eff_shift;
    end

    generate
        if (ACC_W > RES_W) begin : g_sat
            always_comb begin
                scaled = (|shifted[ACC_W-1:RES_W]) ? {RES_W{1'b1}} : shifted[RES_W-1:0];
            end
        end else begin : g_wide
            always_comb begin
                scaled = RES_W'(shifted);
            end
        end
    endgenerate
endmodule

// File: rtl/ovs_ctrl.sv
module ovs_ctrl #(
    parameter int SAMPLE_W = 12,
    parameter int RES_W    = 16,
    parameter int CODE_W   = 3,
    parameter int SHIFT_W  = 4,
    parameter int CNT_W    = 8,
    parameter int ACC_W    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                cont_mode,
    input  logic                trigger,
    input  logic [CODE_W-1:0]   ratio_code,
    input  logic [SHIFT_W-1:0]  shift_amt,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [ACC_W-1:0]    grp_sum,
    output logic [SHIFT_W-1:0]  grp_shift,
    input  logic [RES_W-1:0]    scaled,
    output logic [RES_W-1:0]    result,
    output logic                done,
    output logic                busy
);
    typedef struct packed {
        logic                busy;
        logic                cont;
        logic [CODE_W-1:0]   code;
        logic [SHIFT_W-1:0]  shift;
        logic [CNT_W-1:0]    cnt;
        logic [ACC_W-1:0]    acc;
        logic [RES_W-1:0]    res;
        logic                done;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W:0]   n_full;
    logic             last_smp;
    logic             abort;

    always_comb begin
        n_full   = {{CNT_W{1'b0}}, 1'b1} << ({1'b0, st_q.code} + (CODE_W+1)'(1));
        last_smp = ({1'b0, st_q.cnt} == (n_full - (CNT_W+1)'(1)));
        abort    = !enable || (st_q.cont && !cont_mode);
        grp_sum  = st_q.acc + ACC_W'(smp_data);
        grp_shift = st_q.shift;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (enable && trigger) begin
                st_d.busy  = 1'b1;
                st_d.cont  = cont_mode;
                st_d.code  = ratio_code;
                st_d.shift = shift_amt;
                st_d.cnt   = '0;
                st_d.acc   = '0;
            end
        end else if (abort) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
            st_d.acc  = '0;
        end else if (smp_valid) begin
            if (last_smp) begin
                st_d.res  = scaled;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
                st_d.acc  = '0;
                if (st_q.cont) begin
                    st_d.code  = ratio_code;
                    st_d.shift = shift_amt;
                end else begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.acc = grp_sum;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;
    assign done   = st_q.done;
    assign busy   = st_q.busy;

    // Done never lasts two cycles (smallest group is two samples).
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.busy));
    p_single_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !st_q.cont) |-> !st_q.busy);
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !enable) |=> (!st_q.busy && !st_q.done && $stable(st_q.res)));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !(enable && trigger)) |=> (!st_q.busy && $stable(st_q.res)));
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> ({1'b0, st_q.cnt} < n_full));
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
    import ovs_pkg::*;
#(
    parameter int P_SAMPLE_W  = SAMPLE_W,
    parameter int P_RES_W     = RES_W,
    parameter int P_CODE_W    = CODE_W,
    parameter int P_SHIFT_W   = SHIFT_W,
    parameter int P_MAX_SHIFT = MAX_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  cont_mode,
    input  logic                  trigger,
    input  logic [P_CODE_W-1:0]   ratio_code,
    input  logic [P_SHIFT_W-1:0]  shift_amt,
    input  logic                  smp_valid,
    input  logic [P_SAMPLE_W-1:0] smp_data,
    output logic [P_RES_W-1:0]    result,
    output logic                  done,
    output logic                  busy
);
    localparam int MAX_LOG2 = 1 << P_CODE_W;
    localparam int CNT_W    = MAX_LOG2;
    localparam int ACC_W    = P_SAMPLE_W + MAX_LOG2;

    logic [ACC_W-1:0]     grp_sum;
    logic [P_SHIFT_W-1:0] grp_shift;
    logic [P_RES_W-1:0]   scaled;

    ovs_ctrl #(
        .SAMPLE_W (P_SAMPLE_W),
        .RES_W    (P_RES_W),
        .CODE_W   (P_CODE_W),
        .SHIFT_W  (P_SHIFT_W),
        .CNT_W    (CNT_W),
        .ACC_W    (ACC_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cont_mode  (cont_mode),
        .trigger    (trigger),
        .ratio_code (ratio_code),
        .shift_amt  (shift_amt),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .grp_sum    (grp_sum),
        .grp_shift  (grp_shift),
        .scaled     (scaled),
        .result     (result),
        .done       (done),
        .busy       (busy)
    );

    ovs_scale #(
        .ACC_W     (ACC_W),
        .RES_W     (P_RES_W),
        .SHIFT_W   (P_SHIFT_W),
        .MAX_SHIFT (P_MAX_SHIFT)
    ) u_scale (
        .sum    (grp_sum),
        .shift  (grp_shift),
        .scaled (scaled)
    );
endmodule

// File: tb/ovs_accum_tb.sv
module ovs_accum_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cont_mode = 1'b0;
    logic        trigger = 1'b0;
    logic [2:0]  ratio_code = '0;
    logic [3:0]  shift_amt = '0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [15:0] result;
    logic        done;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ovs_accum u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cont_mode(cont_mode),
        .trigger(trigger), .ratio_code(ratio_code), .shift_amt(shift_amt),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .result(result), .done(done), .busy(busy)
    );

    // Behavioural reference model
    int m_res = 0;
    bit m_done = 0;
    bit m_busy = 0;
    bit m_cont = 0;
    int m_n = 2;
    int m_sh = 0;
    int smpq[$];

    function automatic int clamp_sh(input int s);
        return (s > 8) ? 8 : s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_res = 0; m_done = 0; m_busy = 0; m_cont = 0;
            smpq.delete();
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (enable && trigger) begin
                    m_busy = 1; m_cont = cont_mode;
                    m_n = 1 << (int'(ratio_code) + 1);
                    m_sh = clamp_sh(int'(shift_amt));
                    smpq.delete();
                end
            end else if (!enable || (m_cont && !cont_mode)) begin
                m_busy = 0;
                smpq.delete();
            end else if (smp_valid) begin
                smpq.push_back(int'(smp_data));
                if (smpq.size() == m_n) begin
                    int tot;
                    int v;
                    tot = 0;
                    foreach (smpq[k]) tot += smpq[k];
                    v = tot >> m_sh;
                    m_res = (v > 65535) ? 65535 : v;
                    m_done = 1;
                    smpq.delete();
                    if (m_cont) begin
                        m_n = 1 << (int'(ratio_code) + 1);
                        m_sh = clamp_sh(int'(shift_amt));
                    end else begin
                        m_busy = 0;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(result) != m_res || done != m_done || busy != m_busy) begin
                errors++;
                $display("FAIL R3/R6/R7 model compare: result=%0d done=%0b busy=%0b expected result=%0d done=%0b busy=%0b",
                         result, done, busy, m_res, m_done, m_busy);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input int code, input int sh, input bit cm);
        ratio_code = 3'(code); shift_amt = 4'(sh); cont_mode = cm; trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    // Leaves the bench at the negedge right after the last sample is captured.
    task automatic feed(input int base, input int step, input int cnt, input int gap);
        for (int i = 0; i < cnt; i++) begin
            smp_valid = 1'b1;
            smp_data = 12'((base + i * step) & 12'hFFF);
            @(negedge clk);
            smp_valid = 1'b0;
            if (i != cnt - 1) repeat (gap) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 result", int'(result), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 busy", int'(busy), 0);

        // R12 trigger with enable low
        start(1, 0, 0);
        chk("R12 busy", int'(busy), 0);
        enable = 1'b1;

        // R10 strobes while idle
        feed(1000, 1, 3, 0);
        chk("R10 busy", int'(busy), 0);
        chk("R10 result", int'(result), 0);

        // R2, R3, R6, R7: N=64, shift 2, full scale
        start(5, 2, 0);
        chk("R2 busy", int'(busy), 1);
        feed(4095, 0, 64, 0);
        chk("R3 full-scale result", int'(result), 65520);
        chk("R6 done", int'(done), 1);
        chk("R7 busy low", int'(busy), 0);
        @(negedge clk);
        chk("R6 done one cycle", int'(done), 0);
        chk("R6 result held", int'(result), 65520);

        // R3 N=2, gaps between samples
        start(0, 0, 0);
        feed(100, 100, 2, 3);
        chk("R3 N2 result", int'(result), 300);

        // R4 saturation
        start(7, 0, 0);
        feed(4095, 0, 256, 0);
        chk("R4 sat N256", int'(result), 65535);
        start(4, 0, 0);
        feed(2100, 0, 32, 1);
        chk("R4 sat N32", int'(result), 65535);

        // R5 shift clamp
        start(7, 15, 0);
        feed(4095, 0, 256, 0);
        chk("R5 shift clamp", int'(result), 4095);

        // R11 trigger while busy
        start(1, 0, 0);
        feed(10, 0, 2, 0);
        ratio_code = 3'd3; trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        feed(10, 0, 2, 0);
        chk("R11 done after 4", int'(done), 1);
        chk("R11 result", int'(result), 40);

        // R9 abort by enable
        start(1, 0, 0);
        feed(500, 0, 2, 0);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 busy after abort", int'(busy), 0);
        chk("R9 done after abort", int'(done), 0);
        chk("R9 result kept", int'(result), 40);
        enable = 1'b1;
        start(1, 0, 0);
        feed(5, 0, 4, 0);
        chk("R9 fresh sum", int'(result), 20);

        // R8 continuous with group-size change at boundary
        start(0, 0, 1);
        ratio_code = 3'd1;
        feed(1, 1, 2, 0);
        chk("R8 first result", int'(result), 3);
        chk("R8 busy kept", int'(busy), 1);
        feed(1, 1, 4, 1);
        chk("R8 second result", int'(result), 10);
        chk("R8 second done", int'(done), 1);
        chk("R8 still busy", int'(busy), 1);
        // R9 abort by dropping continuous flag
        feed(9, 0, 1, 0);
        cont_mode = 1'b0;
        @(negedge clk);
        chk("R9 cont abort busy", int'(busy), 0);
        chk("R9 cont abort result", int'(result), 10);
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule